// File: doc/BRIEF.md
# Dual-Mode Down-Counting Timer

This block is a 16-bit down-counter driven by enable ticks from one of two tick sources. Software writes a start value into a load register. The counter takes that value on the same clock edge, then loses one count for each active tick while the run bit is set. When the counter is at zero and a tick arrives, the counter underflows and the interrupt output rises on that same edge.

What happens after an underflow depends on the mode. In free-running mode the counter continues from 0xFFFF. In periodic mode it reloads the value that was last written, so a start value N repeats every N+1 ticks. This makes the block useful as a rate generator or as a source of periodic interrupts. The interrupt stays high until software writes to the clear address.

A simple synchronous register port gives access to the block. Reads are combinational and have no side effects, so the live count can be read at any moment.

Top module: `dual_mode_down_timer`

## Requirements
- R1: After reset, the count, the load register and the control register all read 0, and irq_o is low.
- R2: A write to address 0 sets both the load register and the count to wr_data_i on that clock edge. A tick that arrives in the same cycle as this write does not decrement, so the first decrement comes on the next active tick.
- R3: rd_data_o shows the register selected by rd_addr_i: 0 gives the load register, 1 the live count, 2 the control bits in [2:0], and 3 reads as 0. Reading never changes the count.
- R4: While control bit 0 (run) is 1, each selected tick lowers a nonzero count by one. While run is 0, the count holds.
- R5: Control bit 2 picks the tick source: 0 selects tick_fast_i and 1 selects tick_slow_i. The source that is not selected has no effect.
- R6: With control bit 1 at 0 (free-running), a selected tick at count 0 makes the count 0xFFFF, and counting continues down from there.
- R7: With control bit 1 at 1 (periodic), a selected tick at count 0 reloads the last value written to address 0, so a load value N gives a period of N+1 ticks.
- R8: irq_o rises on the same clock edge as an underflow.
- R9: A write of any data to address 3 lowers irq_o. If an underflow happens in the same cycle as this write, irq_o stays high.
- R10: Writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast_i | input | 1 | Enable tick, fast source |
| tick_slow_i | input | 1 | Enable tick, slow source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data (combinational) |
| irq_o | output | 1 | Underflow interrupt, held until cleared |

## Verification
The counting path is tested with several stimulus patterns, and each one separates a different pair of behaviours:
- Runs of fast ticks with run set and with run clear separate decrementing from holding.
- Ticks on the source that is not selected, with the select bit toggled, show which source actually drives the counter.
- Underflows from a small load value distinguish wrapping to 0xFFFF from reloading.
- In periodic mode, counting the ticks between interrupts confirms the N+1 period.

Same-cycle collisions get their own checks: a write together with a tick shows that the load wins, and a clear together with an underflow shows that the set wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      SEL_LOAD  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_CLEAR = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic src_slow;
      logic periodic;
      logic run;
   } ctrl_t;

   localparam int CTRL_BITS = $bits(ctrl_t);
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int AW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   input  logic [WIDTH-1:0] cnt,
   output logic             load_we,
   output logic             clr_we,
   output logic [WIDTH-1:0] reload_val,
   output ctrl_t            ctrl,
   output logic [WIDTH-1:0] rd_data
);
   initial begin
      if (WIDTH <= CTRL_BITS) $error("WIDTH must exceed control field width");
      if (AW < 2) $error("AW must be at least 2");
   end

   assign load_we = wr_en && (wr_addr == AW'(SEL_LOAD));
   assign clr_we  = wr_en && (wr_addr == AW'(SEL_CLEAR));

   logic ctrl_we;
   assign ctrl_we = wr_en && (wr_addr == AW'(SEL_CTRL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_val <= '0;
         ctrl       <= '0;
      end else begin
         if (load_we) reload_val <= wr_data;
         if (ctrl_we) ctrl <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         AW'(SEL_LOAD):  rd_data = reload_val;
         AW'(SEL_COUNT): rd_data = cnt;
         AW'(SEL_CTRL):  rd_data[CTRL_BITS-1:0] = ctrl;
         default:        rd_data = '0;
      endcase
   end

   // R10: writes to the count address leave the load and control registers alone
   a_r10_count_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(SEL_COUNT)) |=> ($stable(reload_val) && $stable(ctrl)));
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
   parameter bit REG_TICK = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_slow,
   input  logic tick_fast,
   input  logic tick_slow,
   output logic tick
);
   logic picked;
   assign picked = src_slow ? tick_slow : tick_fast;

   generate
      if (REG_TICK) begin : g_reg
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= picked;
         end
         assign tick = q;
      end else begin : g_comb
         assign tick = picked;
      end
   endgenerate
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_we,
   input  logic [WIDTH-1:0] load_data,
   input  logic [WIDTH-1:0] reload_val,
   input  logic             run,
   input  logic             periodic,
   input  logic             tick,
   input  logic             clr,
   output logic [WIDTH-1:0] cnt,
   output logic             irq
);
   localparam logic [WIDTH-1:0] CNT_MAX = '1;

   logic step, underflow;
   assign step      = tick && run && !load_we;
   assign underflow = step && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load_we) begin
         cnt <= load_data;
      end else if (underflow) begin
         cnt <= periodic ? reload_val : CNT_MAX;
      end else if (step) begin
         cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         irq <= 1'b0;
      else if (underflow) irq <= 1'b1;
      else if (clr)       irq <= 1'b0;
   end

   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_we |=> (cnt == $past(load_data)));
   a_r4_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !load_we && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_we && !(tick && run)) |=> $stable(cnt));
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !load_we && cnt == '0 && !periodic) |=> (cnt == CNT_MAX));
   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !load_we && cnt == '0 && periodic) |=> (cnt == $past(reload_val)));
   a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !load_we && cnt == '0) |=> irq);
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(tick && run && !load_we && cnt == '0)) |=> !irq);
endmodule

// File: rtl/dual_mode_down_timer.sv
module dual_mode_down_timer
   import tmr_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int AW       = 2,
   parameter bit REG_TICK = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_fast_i,
   input  logic             tick_slow_i,
   input  logic             wr_en_i,
   input  logic [AW-1:0]    wr_addr_i,
   input  logic [WIDTH-1:0] wr_data_i,
   input  logic [AW-1:0]    rd_addr_i,
   output logic [WIDTH-1:0] rd_data_o,
   output logic             irq_o
);
   logic             load_we, clr_we, tick;
   logic [WIDTH-1:0] reload_val, cnt;
   ctrl_t            ctrl;

   tmr_regs #(.WIDTH(WIDTH), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
      .wr_data(wr_data_i), .rd_addr(rd_addr_i), .cnt(cnt),
      .load_we(load_we), .clr_we(clr_we), .reload_val(reload_val),
      .ctrl(ctrl), .rd_data(rd_data_o)
   );

   tmr_tick_sel #(.REG_TICK(REG_TICK)) u_tick (
      .clk(clk), .rst_n(rst_n), .src_slow(ctrl.src_slow),
      .tick_fast(tick_fast_i), .tick_slow(tick_slow_i), .tick(tick)
   );

   tmr_core #(.WIDTH(WIDTH)) u_core (
      .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_data(wr_data_i),
      .reload_val(reload_val), .run(ctrl.run), .periodic(ctrl.periodic),
      .tick(tick), .clr(clr_we), .cnt(cnt), .irq(irq_o)
   );
endmodule

// File: tb/tb_dual_mode_down_timer.sv
module tb_dual_mode_down_timer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_fast_i = 1'b0, tick_slow_i = 1'b0, wr_en_i = 1'b0;
   logic [1:0]  wr_addr_i = '0, rd_addr_i = '0;
   logic [15:0] wr_data_i = '0;
   logic [15:0] rd_data_o;
   logic        irq_o;
   int          n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_mode_down_timer dut (.*);

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one clock edge with the given inputs, returns at the next negedge
   task automatic step(bit we, logic [1:0] a, logic [15:0] d, bit tf, bit ts);
      wr_en_i = we; wr_addr_i = a; wr_data_i = d;
      tick_fast_i = tf; tick_slow_i = ts;
      @(negedge clk);
      wr_en_i = 0; tick_fast_i = 0; tick_slow_i = 0;
   endtask

   task automatic rd(logic [1:0] a, output logic [15:0] v);
      rd_addr_i = a; #1; v = rd_data_o;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      rd(0, v); chk("R1 load", v, 0);
      rd(1, v); chk("R1 count", v, 0);
      rd(2, v); chk("R1 ctrl", v, 0);
      chk("R1 irq", irq_o, 0);
   endtask

   task automatic t_load_count();
      logic [15:0] v;
      step(1, 0, 16'd5, 0, 0);
      rd(1, v); chk("R2 count", v, 5);
      rd(0, v); chk("R2 loadreg", v, 5);
      step(1, 2, 16'h1, 0, 0);
      rd(2, v); chk("R3 ctrl read", v, 1);
      rd(3, v); chk("R3 addr3 zero", v, 0);
      repeat (3) step(0, 0, 0, 1, 0);
      rd(1, v); chk("R4 three ticks", v, 2);
      rd(1, v); chk("R3 read no effect", v, 2);
      step(0, 0, 0, 0, 0);
      rd(1, v); chk("R4 no tick hold", v, 2);
      step(1, 2, 16'h0, 0, 0);
      step(0, 0, 0, 1, 0);
      rd(1, v); chk("R4 run off hold", v, 2);
   endtask

   task automatic t_source();
      logic [15:0] v;
      step(1, 2, 16'h1, 0, 0);
      step(0, 0, 0, 0, 1);
      rd(1, v); chk("R5 slow ignored", v, 2);
      step(1, 2, 16'h5, 0, 0);
      step(0, 0, 0, 1, 0);
      rd(1, v); chk("R5 fast ignored", v, 2);
      step(0, 0, 0, 0, 1);
      rd(1, v); chk("R5 slow counts", v, 1);
   endtask

   task automatic t_wrap();
      logic [15:0] v;
      step(1, 2, 16'h1, 0, 0);
      step(1, 0, 16'd1, 0, 0);
      step(0, 0, 0, 1, 0);
      rd(1, v); chk("R6 to zero", v, 0);
      chk("R8 no irq yet", irq_o, 0);
      step(0, 0, 0, 1, 0);
      rd(1, v); chk("R6 wrap", v, 16'hFFFF);
      chk("R8 irq set", irq_o, 1);
      step(0, 0, 0, 1, 0);
      rd(1, v); chk("R6 continue", v, 16'hFFFE);
      step(1, 3, 16'h0, 0, 0);
      chk("R9 cleared", irq_o, 0);
   endtask

   task automatic t_periodic();
      logic [15:0] v;
      step(1, 2, 16'h3, 0, 0);
      step(1, 0, 16'd2, 0, 0);
      step(0, 0, 0, 1, 0);
      step(0, 0, 0, 1, 0);
      rd(1, v); chk("R7 at zero", v, 0);
      chk("R7 no irq before N+1", irq_o, 0);
      step(0, 0, 0, 1, 0);
      rd(1, v); chk("R7 reload", v, 2);
      chk("R8 irq periodic", irq_o, 1);
      step(1, 3, 16'h0, 0, 0);
      step(0, 0, 0, 1, 0);
      step(0, 0, 0, 1, 0);
      // underflow and clear together: set wins
      step(1, 3, 16'h0, 1, 0);
      chk("R9 set wins", irq_o, 1);
      rd(1, v); chk("R7 second reload", v, 2);
   endtask

   task automatic t_collide();
      logic [15:0] v;
      step(1, 0, 16'd7, 1, 0);
      rd(1, v); chk("R2 write beats tick", v, 7);
      step(0, 0, 0, 1, 0);
      rd(1, v); chk("R2 next tick", v, 6);
      step(1, 1, 16'h1234, 0, 0);
      rd(1, v); chk("R10 count", v, 6);
      rd(0, v); chk("R10 loadreg", v, 7);
      rd(2, v); chk("R10 ctrl", v, 3);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load_count();
      t_source();
      t_wrap();
      t_periodic();
      t_collide();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule